// File: doc/BRIEF.md
# Power Domain Control Register Unit

This block is a register-mapped controller for up to 16 power domains. Software writes a power-switch request and an idle request for each domain through a single-cycle register port. The block models each domain's power switch, which settles only after a programmable transition count. It also models each domain's bus-interface idle handshake, which runs with a small fixed latency. Per-domain power status, idle acknowledge and idle status are available both as direct outputs and through register reads.

Both control registers use half-word write masking. A write changes bit n only when bit n+16 of the same write data is 1, so each domain can be changed without first reading the register. Power status is active-low "on": a 0 means the domain is powered. Power-down and power-up have separate count registers at consecutive word addresses. After reset both counts are 24, which is one microsecond at a 24 MHz reference.

Top module: `pdc_unit`

## Requirements
- R1: A write to the power control register (0x00) or the idle request register (0x08) sets control bit n to wdata[n] only when wdata[n+16] is 1. Bits whose mask bit is 0 keep their value. Control bit 1 requests off or idle; 0 requests on or leaving idle.
- R2: Reads of 0x00 and 0x08 return the current control bits in [NUM_DOM-1:0] and zeros in [31:16].
- R3: Power status (read at 0x04 and on pwr_off_o) is 0 for a powered domain and 1 for a domain that is off.
- R4: If a power control bit is written at clock edge E and no further change follows, the status bit of that domain flips at edge E+N+2. N is the down count (0x20) for power-off and the up count (0x24) for power-on.
- R5: Each change of a domain's power request restarts its count toward the new target. A request that returns to the current status before the count expires leaves the status unchanged.
- R6: Idle acknowledge (0x0C, idle_ack_o) follows the idle request bit 4 cycles later. Idle status (0x10, idle_stat_o) follows the acknowledge 2 cycles later. This holds for both assertion and withdrawal.
- R7: After reset, all domains are powered, no idle request is set, acknowledge and idle status are 0, and both count registers read 24.
- R8: Writes to the read-only addresses (0x04, 0x0C, 0x10) or to unmapped addresses change no control, count or status state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Byte address for both write and read |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| pwr_off_o | output | NUM_DOM | Power status per domain, 1 = off |
| idle_ack_o | output | NUM_DOM | Idle acknowledge per domain |
| idle_stat_o | output | NUM_DOM | Idle status per domain |

## Verification
On every cycle, the assertions check the following:
- The masked-write update and the hold of unmasked or unaddressed bits.
- That a status flip always moves toward the request seen on the previous edge.
- That no status flips on the edge where a request change is taken in.
- The exact 4-cycle and 2-cycle handshake delays.

Only the bench scenarios can show certain other behaviour. One is the full E+N+2 settling time for various programmed counts. Another is the restart of a count after a late retarget. The last is the reset values of the count registers as seen over the read port.

// File: rtl/pdc_pkg.sv
package pdc_pkg;
  localparam int unsigned ADR_PWR   = 'h00;
  localparam int unsigned ADR_PSTAT = 'h04;
  localparam int unsigned ADR_IREQ  = 'h08;
  localparam int unsigned ADR_IACK  = 'h0C;
  localparam int unsigned ADR_ISTAT = 'h10;
  localparam int unsigned ADR_DCNT  = 'h20;
  localparam int unsigned ADR_UCNT  = 'h24;  // must stay ADR_DCNT + 4
  localparam int unsigned ACK_LAT   = 4;
  localparam int unsigned IDLE_LAT  = 2;
endpackage

// File: rtl/pdc_mask_reg.sv
module pdc_mask_reg #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [31:0]  wdata_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q;

  for (genvar n = 0; n < W; n++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                      q_q[n] <= 1'b0;
      else if (we_i && wdata_i[n + 16]) q_q[n] <= wdata_i[n];
    end
  end

  assign q_o = q_q;

  assert_masked_update_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> q_o == (($past(q_o) & ~$past(wdata_i[16 +: W])) |
                     ($past(wdata_i[W-1:0]) & $past(wdata_i[16 +: W]))));
  assert_hold_unwritten_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(q_o));
endmodule

// File: rtl/pdc_switch.sv
module pdc_switch #(
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          off_req_i,
  input  logic [CW-1:0] dn_cnt_i,
  input  logic [CW-1:0] up_cnt_i,
  output logic          off_o
);
  logic          last_q;
  logic          off_q;
  logic [CW-1:0] cnt_q;
  logic          req_chg;

  assign req_chg = off_req_i != last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_q <= 1'b0;
      off_q  <= 1'b0;
      cnt_q  <= '0;
    end else if (req_chg) begin
      // retarget: reload the count toward the new target
      last_q <= off_req_i;
      cnt_q  <= off_req_i ? dn_cnt_i : up_cnt_i;
    end else if (off_q != last_q) begin
      if (cnt_q == '0) off_q <= last_q;
      else             cnt_q <= cnt_q - CW'(1);
    end
  end

  assign off_o = off_q;

  assert_flip_toward_req_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(off_o) |-> off_o == $past(off_req_i));
  assert_no_flip_on_retarget_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_chg |=> $stable(off_o));
endmodule

// File: rtl/pdc_idle.sv
module pdc_idle
  import pdc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic ack_o,
  output logic idle_o
);
  localparam int unsigned DL = ACK_LAT + IDLE_LAT;
  logic [DL-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[DL-2:0], req_i};
  end

  assign ack_o  = sh_q[ACK_LAT-1];
  assign idle_o = sh_q[DL-1];

  // literal depths match the fixed ACK_LAT=4 and IDLE_LAT=2
  assert_ack_delay_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o == $past(req_i, 4));
  assert_idle_delay_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_o == $past(ack_o, 2));
endmodule

// File: rtl/pdc_unit.sv
module pdc_unit
  import pdc_pkg::*;
#(
  parameter int unsigned NUM_DOM = 16,
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned CNT_RST = 24,
  parameter int unsigned ADDR_W  = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [31:0]        wdata_i,
  output logic [31:0]        rdata_o,
  output logic [NUM_DOM-1:0] pwr_off_o,
  output logic [NUM_DOM-1:0] idle_ack_o,
  output logic [NUM_DOM-1:0] idle_stat_o
);
  localparam logic [ADDR_W-1:0] A_PWR   = ADDR_W'(ADR_PWR);
  localparam logic [ADDR_W-1:0] A_PSTAT = ADDR_W'(ADR_PSTAT);
  localparam logic [ADDR_W-1:0] A_IREQ  = ADDR_W'(ADR_IREQ);
  localparam logic [ADDR_W-1:0] A_IACK  = ADDR_W'(ADR_IACK);
  localparam logic [ADDR_W-1:0] A_ISTAT = ADDR_W'(ADR_ISTAT);
  localparam logic [ADDR_W-1:0] A_DCNT  = ADDR_W'(ADR_DCNT);
  localparam logic [ADDR_W-1:0] A_UCNT  = ADDR_W'(ADR_UCNT);
  localparam logic [CNT_W-1:0]  CNT_INIT = CNT_W'(CNT_RST);

  initial begin
    if (NUM_DOM < 1 || NUM_DOM > 16) $error("NUM_DOM must be 1..16");
    if (CNT_W < 5 || CNT_W > 32) $error("CNT_W must be 5..32");
  end

  logic [NUM_DOM-1:0] pwr_ctrl, ireq_ctrl;
  logic [CNT_W-1:0]   dn_cnt_q, up_cnt_q;

  pdc_mask_reg #(.W(NUM_DOM)) u_pwr_reg (
    .clk_i, .rst_ni,
    .we_i   (wr_en_i && addr_i == A_PWR),
    .wdata_i,
    .q_o    (pwr_ctrl)
  );

  pdc_mask_reg #(.W(NUM_DOM)) u_ireq_reg (
    .clk_i, .rst_ni,
    .we_i   (wr_en_i && addr_i == A_IREQ),
    .wdata_i,
    .q_o    (ireq_ctrl)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dn_cnt_q <= CNT_INIT;
      up_cnt_q <= CNT_INIT;
    end else if (wr_en_i) begin
      if (addr_i == A_DCNT) dn_cnt_q <= wdata_i[CNT_W-1:0];
      if (addr_i == A_UCNT) up_cnt_q <= wdata_i[CNT_W-1:0];
    end
  end

  for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
    pdc_switch #(.CW(CNT_W)) u_sw (
      .clk_i, .rst_ni,
      .off_req_i (pwr_ctrl[d]),
      .dn_cnt_i  (dn_cnt_q),
      .up_cnt_i  (up_cnt_q),
      .off_o     (pwr_off_o[d])
    );
    pdc_idle u_idle (
      .clk_i, .rst_ni,
      .req_i  (ireq_ctrl[d]),
      .ack_o  (idle_ack_o[d]),
      .idle_o (idle_stat_o[d])
    );
  end

  always_comb begin
    unique case (addr_i)
      A_PWR:   rdata_o = 32'(pwr_ctrl);
      A_PSTAT: rdata_o = 32'(pwr_off_o);
      A_IREQ:  rdata_o = 32'(ireq_ctrl);
      A_IACK:  rdata_o = 32'(idle_ack_o);
      A_ISTAT: rdata_o = 32'(idle_stat_o);
      A_DCNT:  rdata_o = 32'(dn_cnt_q);
      A_UCNT:  rdata_o = 32'(up_cnt_q);
      default: rdata_o = '0;
    endcase
  end

  assert_ctrl_upper_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == A_PWR || addr_i == A_IREQ) |-> rdata_o[31:16] == 16'h0);
  assert_cnt_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && (addr_i == A_DCNT || addr_i == A_UCNT)) |=>
      $stable(dn_cnt_q) && $stable(up_cnt_q));
endmodule

// File: tb/tb_pdc_unit.sv
module tb_pdc_unit;
  import pdc_pkg::*;
  localparam int ND = 4;

  logic          clk_i = 0, rst_ni = 0, wr_en_i = 0;
  logic [7:0]    addr_i = 0;
  logic [31:0]   wdata_i = 0;
  logic [31:0]   rdata_o;
  logic [ND-1:0] pwr_off_o, idle_ack_o, idle_stat_o;

  int total = 0, passed = 0;
  bit done = 0;

  pdc_unit #(.NUM_DOM(ND)) dut (.*);

  always #4 clk_i = ~clk_i;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act === exp) passed++;
    else $display("FAIL %s actual=%h expected=%h", req, act, exp);
  endtask

  task automatic wr(int unsigned a, logic [31:0] d);
    @(negedge clk_i); wr_en_i = 1; addr_i = 8'(a); wdata_i = d;
    @(negedge clk_i); wr_en_i = 0;
  endtask

  task automatic rd(int unsigned a, output logic [31:0] d);
    addr_i = 8'(a); #1; d = rdata_o;
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk_i);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      total++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", passed, total);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [ND-1:0] pm, im;
    cyc(5); rst_ni = 1; cyc(1);

    // R7 / R3 reset state
    rd(ADR_PWR, r);   chk("R7 pwr ctrl", r, 0);
    rd(ADR_IREQ, r);  chk("R7 idle req", r, 0);
    rd(ADR_PSTAT, r); chk("R3 status on", r, 0);
    rd(ADR_IACK, r);  chk("R7 ack", r, 0);
    rd(ADR_ISTAT, r); chk("R7 idle stat", r, 0);
    rd(ADR_DCNT, r);  chk("R7 down count", r, 24);
    rd(ADR_UCNT, r);  chk("R7 up count", r, 24);

    // R1 / R2 exhaustive mask x data sweep on power control
    pm = '0;
    for (int m = 0; m < 16; m++)
      for (int d = 0; d < 16; d++) begin
        wr(ADR_PWR, {12'h5A3, 4'(m), 12'hC3F, 4'(d)});
        pm = (pm & ~4'(m)) | (4'(d) & 4'(m));
        rd(ADR_PWR, r);
        chk("R1 R2 pwr masked", r, 32'(pm));
      end
    im = '0;
    for (int m = 0; m < 16; m++) begin
      wr(ADR_IREQ, {12'h0, 4'(m), 12'h0, 4'(m ^ 5)});
      im = (im & ~4'(m)) | (4'(m ^ 5) & 4'(m));
      rd(ADR_IREQ, r);
      chk("R1 R2 ireq masked", r, 32'(im));
    end
    wr(ADR_PWR, 32'h000F_0000);
    wr(ADR_IREQ, 32'h000F_0000);
    cyc(80);
    rd(ADR_PSTAT, r); chk("R3 all on again", r, 0);
    rd(ADR_ISTAT, r); chk("R6 idle cleared", r, 0);

    // R8 writes to read-only / unmapped addresses
    wr(ADR_PSTAT, 32'hFFFF_FFFF);
    wr(ADR_IACK, 32'hFFFF_FFFF);
    wr(ADR_ISTAT, 32'hFFFF_FFFF);
    wr('h30, 32'hFFFF_FFFF);
    cyc(40);
    rd(ADR_PWR, r);   chk("R8 pwr ctrl kept", r, 0);
    rd(ADR_IREQ, r);  chk("R8 ireq kept", r, 0);
    rd(ADR_PSTAT, r); chk("R8 status kept", r, 0);
    rd(ADR_ISTAT, r); chk("R8 idle stat kept", r, 0);
    rd(ADR_DCNT, r);  chk("R8 dcount kept", r, 24);
    rd(ADR_UCNT, r);  chk("R8 ucount kept", r, 24);

    // R4 settling for several counts, off then on
    for (int k = 0; k < 4; k++) begin
      int n = (k * 3) + (k == 3 ? 1 : 0);
      int u = n + 2;
      wr(ADR_DCNT, 32'(n));
      wr(ADR_UCNT, 32'(u));
      rd(ADR_UCNT, r); chk("R4 up count reg", r, 32'(u));
      wr(ADR_PWR, 32'h1_0001 << k);
      cyc(n + 1); chk("R4 off not yet", 32'(pwr_off_o[k]), 0);
      cyc(1);     chk("R4 off at N+2", 32'(pwr_off_o[k]), 1);
      rd(ADR_PSTAT, r); chk("R3 off reads 1", r, 32'(1 << k));
      wr(ADR_PWR, 32'h1_0000 << k);
      cyc(u + 1); chk("R4 on not yet", 32'(pwr_off_o[k]), 1);
      cyc(1);     chk("R4 on at N+2", 32'(pwr_off_o[k]), 0);
    end

    // R5 retarget restarts the count
    wr(ADR_DCNT, 10);
    wr(ADR_UCNT, 30);
    wr(ADR_PWR, 32'h0002_0002);
    cyc(3);
    wr(ADR_PWR, 32'h0002_0000);
    cyc(2);
    wr(ADR_PWR, 32'h0002_0002);
    cyc(11); chk("R5 restarted count pending", 32'(pwr_off_o[1]), 0);
    cyc(1);  chk("R5 flips after full restart", 32'(pwr_off_o[1]), 1);
    wr(ADR_PWR, 32'h0002_0000);
    cyc(10);
    wr(ADR_PWR, 32'h0002_0002);
    cyc(60); chk("R5 reverted request keeps off", 32'(pwr_off_o[1]), 1);
    wr(ADR_PWR, 32'h0002_0000);
    cyc(40); chk("R5 back on", 32'(pwr_off_o[1]), 0);

    // R6 handshake timing per domain
    for (int d = 0; d < ND; d++) begin
      wr(ADR_IREQ, 32'h1_0001 << d);
      cyc(3); chk("R6 ack not yet", 32'(idle_ack_o[d]), 0);
      cyc(1); chk("R6 ack at 4", 32'(idle_ack_o[d]), 1);
      cyc(1); chk("R6 idle not yet", 32'(idle_stat_o[d]), 0);
      cyc(1); chk("R6 idle at ack+2", 32'(idle_stat_o[d]), 1);
      rd(ADR_IACK, r);  chk("R6 ack reg", r, 32'(1 << d));
      rd(ADR_ISTAT, r); chk("R6 idle reg", r, 32'(1 << d));
      wr(ADR_IREQ, 32'h1_0000 << d);
      cyc(3); chk("R6 ack holds", 32'(idle_ack_o[d]), 1);
      cyc(1); chk("R6 ack drops at 4", 32'(idle_ack_o[d]), 0);
      cyc(1); chk("R6 idle holds", 32'(idle_stat_o[d]), 1);
      cyc(1); chk("R6 idle drops", 32'(idle_stat_o[d]), 0);
    end

    done = 1;
    $display("%0d/%0d checks passed", passed, total);
    $finish;
  end
endmodule